// File: doc/BRIEF.md
# DDR2 SDRAM Power-Up Initialization Sequencer

This block brings an attached DDR2 SDRAM from reset into a usable state. While reset is held, and for a programmable settle time after it, the clock-enable pin stays low and the command pins carry a no-operation. Then clock enable rises and the block issues a fixed command stream. A precharge of all banks comes first, followed by a write of the extended mode register. A second precharge of all banks follows, and the last command writes the main mode register. A programmable number of no-operation cycles separates consecutive commands.

The main mode word sets a burst of eight, sequential ordering and the CAS latency taken from a configuration input. The extended mode word holds additive latency zero with every other option at its default. Once the last mode write and its recovery gap are complete, a ready flag rises. The flag stays high until the next reset, and from then on only no-operations are driven.

Top module: `ddr2_init_seq`

## Requirements
- R1: From reset, and for max(cfg_settle_cycles,1) cycles after reset is released, sd_cke is 0 and the pins carry a no-operation: cs_n=0, ras_n=1, cas_n=1, we_n=1, with bank and address at zero. init_ready is 0.
- R2: After the settle time sd_cke is 1, and it stays 1 until the next reset.
- R3: Exactly four commands are issued, in this order: precharge-all, extended mode write, precharge-all, main mode write. Every mode write is preceded by a precharge-all with no other command in between.
- R4: A precharge-all drives cs_n=0, ras_n=0, cas_n=1 and we_n=0, with sd_addr[10]=1 and all other address bits and all bank bits at 0.
- R5: A mode write drives cs_n, ras_n, cas_n and we_n all to 0. sd_ba=1 selects the extended register and sd_ba=0 selects the main register. sd_addr[12:0] carries the register value and sd_addr[13] is 0.
- R6: The main mode value has bits [2:0]=3'b011 (burst of eight), bit 3=0 (sequential) and bits [6:4]=CAS latency. All other bits are 0.
- R7: A cfg_cas_lat below 2 is written as 2, and a value above 5 is written as 5.
- R8: The extended mode value is all zeros. This gives additive latency 0 in bits [5:3] and default options elsewhere.
- R9: Exactly cfg_gap_cycles no-operation cycles, with sd_cke=1, follow each of the four commands. The first precharge comes in the cycle right after the settle time.
- R10: init_ready rises in the cycle after the gap that follows the main mode write. From then until reset it stays 1, and only no-operations are driven, with no further mode writes.
- R11: Asserting reset at any point restarts the whole sequence from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat | input | 3 | CAS latency to program (2 to 5) |
| cfg_settle_cycles | input | SETTLE_W | Cycles with clock enable low after reset |
| cfg_gap_cycles | input | GAP_W | No-operation cycles after each command |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address, selects mode register |
| sd_addr | output | ADDR_W | Address bus, carries mode value |
| init_ready | output | 1 | Device initialized, sticky until reset |

## Verification
The assertions assume that the three configuration inputs stay constant from reset release until init_ready rises. The sequencer samples them live, so a change mid-sequence would move the gaps and alter the mode word. The bench changes configuration only while reset is held, and it releases reset on a falling clock edge. The random settle and gap values are drawn from small ranges, and the CAS latency is drawn from the full 3-bit range, so the clamping in R7 is reached from both sides. Directed runs cover the zero settle and zero gap cases and a reset applied partway through the stream.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

  typedef enum logic [1:0] {K_NOP, K_PRE, K_MODE} cmd_kind_t;
  typedef enum logic [1:0] {S_SETTLE, S_CMD, S_GAP, S_DONE} seq_state_t;

  localparam int MODE_W = 13;
  localparam logic [MODE_W-1:0] EXT_MODE_WORD = '0;

  // Limit the programmed CAS latency to the supported window 2..5.
  function automatic logic [2:0] clamp_cl(input logic [2:0] cl);
    if (cl < 3'd2)      return 3'd2;
    else if (cl > 3'd5) return 3'd5;
    else                return cl;
  endfunction

  // Main mode word: burst of eight, sequential, latency field in [6:4].
  function automatic logic [MODE_W-1:0] main_mode_word(input logic [2:0] cl);
    return {6'b0, clamp_cl(cl), 1'b0, 3'b011};
  endfunction

endpackage

// File: rtl/ddr2i_timer.sv
module ddr2i_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt;
  logic [W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
  assign last    = cnt_inc >= {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt_inc[W-1:0];
  end
endmodule

// File: rtl/ddr2i_cmd_enc.sv
module ddr2i_cmd_enc
  import ddr2i_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input  cmd_kind_t          kind,
  input  logic               target_ext,
  input  logic [MODE_W-1:0]  word,
  output logic               cs_n,
  output logic               ras_n,
  output logic               cas_n,
  output logic               we_n,
  output logic [BA_W-1:0]    ba,
  output logic [ADDR_W-1:0]  addr
);
  always_comb begin
    cs_n  = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    ba    = '0;
    addr  = '0;
    case (kind)
      K_PRE: begin
        ras_n    = 1'b0;
        we_n     = 1'b0;
        addr[10] = 1'b1;
      end
      K_MODE: begin
        ras_n            = 1'b0;
        cas_n            = 1'b0;
        we_n             = 1'b0;
        ba[0]            = target_ext;
        addr[MODE_W-1:0] = word;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2i_pkg::*;
#(
  parameter int SETTLE_W = 16,
  parameter int GAP_W    = 8,
  parameter int ADDR_W   = 14,
  parameter int BA_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cfg_cas_lat,
  input  logic [SETTLE_W-1:0] cfg_settle_cycles,
  input  logic [GAP_W-1:0]    cfg_gap_cycles,
  output logic                sd_cke,
  output logic                sd_cs_n,
  output logic                sd_ras_n,
  output logic                sd_cas_n,
  output logic                sd_we_n,
  output logic [BA_W-1:0]     sd_ba,
  output logic [ADDR_W-1:0]   sd_addr,
  output logic                init_ready
);
  localparam int CW = (SETTLE_W > GAP_W) ? SETTLE_W : GAP_W;
  localparam logic [1:0] LAST_STEP = 2'd3;

  seq_state_t state, state_nxt;
  logic [1:0] step, step_nxt;
  logic       tmr_clear, tmr_last;
  logic [CW-1:0] tmr_limit;
  logic       gap_zero;

  // named events for the checker
  logic evt_pre, evt_mode, target_ext;
  cmd_kind_t kind;
  logic [MODE_W-1:0] word;

  assign gap_zero  = (cfg_gap_cycles == '0);
  assign tmr_limit = (state == S_SETTLE) ? CW'(cfg_settle_cycles) : CW'(cfg_gap_cycles);

  always_comb begin
    state_nxt = state;
    step_nxt  = step;
    case (state)
      S_SETTLE: if (tmr_last) state_nxt = S_CMD;
      S_CMD: begin
        if (!gap_zero)              state_nxt = S_GAP;
        else if (step == LAST_STEP) state_nxt = S_DONE;
        else                        step_nxt  = step + 2'd1;
      end
      S_GAP: if (tmr_last) begin
        if (step == LAST_STEP) state_nxt = S_DONE;
        else begin
          state_nxt = S_CMD;
          step_nxt  = step + 2'd1;
        end
      end
      default: ;
    endcase
  end

  assign tmr_clear = (state_nxt != state) || (state == S_CMD) || (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_SETTLE;
      step  <= '0;
    end else begin
      state <= state_nxt;
      step  <= step_nxt;
    end
  end

  ddr2i_timer #(.W(CW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tmr_clear),
    .limit (tmr_limit),
    .last  (tmr_last)
  );

  // even steps precharge, odd steps write a mode register; step 1 is extended
  assign evt_pre    = (state == S_CMD) && !step[0];
  assign evt_mode   = (state == S_CMD) &&  step[0];
  assign target_ext = (step == 2'd1);
  assign kind       = evt_mode ? K_MODE : (evt_pre ? K_PRE : K_NOP);
  assign word       = target_ext ? EXT_MODE_WORD : main_mode_word(cfg_cas_lat);

  ddr2i_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .kind       (kind),
    .target_ext (target_ext),
    .word       (word),
    .cs_n       (sd_cs_n),
    .ras_n      (sd_ras_n),
    .cas_n      (sd_cas_n),
    .we_n       (sd_we_n),
    .ba         (sd_ba),
    .addr       (sd_addr)
  );

  assign sd_cke     = (state != S_SETTLE);
  assign init_ready = (state == S_DONE);

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              ready,
  input logic              evt_pre,
  input logic              evt_mode
);
  logic pin_pre, pin_mode, pre_pending;

  assign pin_pre  = !cs_n && !ras_n &&  cas_n && !we_n;
  assign pin_mode = !cs_n && !ras_n && !cas_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_pending <= 1'b0;
    else if (pin_pre)  pre_pending <= 1'b1;
    else if (pin_mode) pre_pending <= 1'b0;
  end

  a_r1_cke_low_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!cs_n && ras_n && cas_n && we_n && !ready));

  a_r2_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  a_r3_pre_before_mode: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mode |-> pre_pending);

  a_r4_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pre |-> (addr[10] && ba == '0));

  a_r5_mode_event_on_pins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_mode |-> (pin_mode && cke));

  a_r4_pre_event_on_pins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pre |-> (pin_pre && cke));

  a_r6_main_word: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode && ba == '0) |-> (addr[2:0] == 3'b011 && !addr[3] &&
                                addr[6:4] >= 3'd2 && addr[6:4] <= 3'd5));

  a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  a_r10_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!pin_mode && !pin_pre));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cke      (sd_cke),
  .cs_n     (sd_cs_n),
  .ras_n    (sd_ras_n),
  .cas_n    (sd_cas_n),
  .we_n     (sd_we_n),
  .ba       (sd_ba),
  .addr     (sd_addr),
  .ready    (init_ready),
  .evt_pre  (evt_pre),
  .evt_mode (evt_mode)
);

// File: tb/sim_ddr2_init_seq.sv
`timescale 1ns/1ps
module sim_ddr2_init_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_cas_lat = 3'd3;
  logic [15:0] cfg_settle_cycles = 16'd0;
  logic [7:0]  cfg_gap_cycles = 8'd0;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_ready;
  logic [2:0]  sd_ba;
  logic [13:0] sd_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ddr2_init_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat),
    .cfg_settle_cycles(cfg_settle_cycles), .cfg_gap_cycles(cfg_gap_cycles),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .init_ready(init_ready)
  );

  // pin vector: {cke, cs_n, ras_n, cas_n, we_n, ba[2:0], addr[13:0], ready}
  function automatic logic [22:0] nop_vec(input logic cke);
    return {cke, 4'b0111, 3'd0, 14'd0, 1'b0};
  endfunction

  function automatic logic [2:0] exp_cl(input logic [2:0] cl);
    return (cl > 3'd5) ? 3'd5 : ((cl < 3'd2) ? 3'd2 : cl);
  endfunction

  // expected pins at sample k after reset release; tag names the requirement
  function automatic logic [22:0] expect_at(input int k, input int s, input int g,
                                            input logic [2:0] cl, output string tag);
    int slot, idx, off;
    logic [13:0] mw;
    slot = g + 1;
    if (k < s) begin tag = "R1"; return nop_vec(1'b0); end
    idx = (k - s) / slot;
    off = (k - s) % slot;
    if (idx >= 4) begin tag = "R10"; return {1'b1, 4'b0111, 3'd0, 14'd0, 1'b1}; end
    if (off != 0) begin tag = "R9"; return nop_vec(1'b1); end
    case (idx)
      0, 2: begin tag = "R4"; return {1'b1, 4'b0010, 3'd0, 14'h0400, 1'b0}; end
      1: begin tag = "R8"; return {1'b1, 4'b0000, 3'd1, 14'd0, 1'b0}; end
      default: begin
        tag = (cl < 3'd2 || cl > 3'd5) ? "R7" : "R6";
        mw = 14'd3 | (14'(exp_cl(cl)) << 4);
        return {1'b1, 4'b0000, 3'd0, mw, 1'b0};
      end
    endcase
  endfunction

  task automatic run_trial(input int s_cfg, input int g, input logic [2:0] cl, input int abort_at);
    int s, total;
    string tag;
    logic [22:0] exp_v, act_v;
    rst_n = 1'b0;
    cfg_settle_cycles = 16'(s_cfg);
    cfg_gap_cycles = 8'(g);
    cfg_cas_lat = cl;
    repeat (2) @(negedge clk);
    // R1: pins during reset
    checks++;
    act_v = {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr, init_ready};
    if (act_v !== nop_vec(1'b0)) begin
      errors++;
      $display("FAIL R1 in reset actual=%h expected=%h", act_v, nop_vec(1'b0));
    end
    rst_n = 1'b1;
    s = (s_cfg < 1) ? 1 : s_cfg;
    total = s + 4 * (g + 1) + 6;
    for (int k = 0; k < total; k++) begin
      if (abort_at >= 0 && k == abort_at) break;  // R11: reset mid-stream
      exp_v = expect_at(k, s, g, cl, tag);
      act_v = {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr, init_ready};
      checks++;
      if (act_v !== exp_v) begin
        errors++;
        $display("FAIL %s (R2/R3/R5 order) k=%0d s=%0d g=%0d cl=%0d actual=%h expected=%h",
                 tag, k, s_cfg, g, cl, act_v, exp_v);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4321));
    @(negedge clk);
    run_trial(0, 0, 3'd0, -1);   // R7 low clamp, zero settle and gap
    run_trial(1, 0, 3'd7, -1);   // R7 high clamp
    run_trial(3, 2, 3'd4, 7);    // R11 abort partway
    run_trial(3, 2, 3'd4, -1);   // R11 restart from scratch
    run_trial(5, 1, 3'd5, -1);   // R6 upper legal value
    run_trial(2, 3, 3'd2, -1);   // R6 lower legal value
    for (int t = 0; t < 10; t++) begin
      run_trial(int'($urandom_range(40, 0)), int'($urandom_range(10, 0)),
                3'($urandom_range(7, 0)), -1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule